// File: doc/BRIEF.md
# CAN Error Flag and Code Store

This unit is the error-reporting slice of a CAN controller's register block. The protocol engine sends one-cycle event pulses for eight error causes: bus error, error warning, error passive, bus-off entry, bus-off recovery, receive overrun, overload frame and bus lock. The unit latches each pulse into a sticky cause flag. A per-cause enable decides which flags feed a single combined error status bit. That bit is one bit of the controller's interrupt status byte, and a separate interrupt enable bit qualifies it into the interrupt line.

Protocol error codes are kept in their own code store, one bit per code. A display-mode bit sets how new codes are kept. With the bit set, codes pile up across events. With it clear, each new error replaces the stored codes. Software clears flags and codes by writing a byte with zero in each bit to be cleared and one everywhere else, so it never needs a read-modify-write. The transmit and receive error counters belong to the protocol engine and are only mirrored here for reading.

Access is through a byte-wide register port. Writes take effect on the clock edge where `we_i` is high. Read data appears one clock after the address is presented. Address map (3-bit): 0 cause flags, 1 cause enables, 2 code store, 3 interrupt enable, 4 interrupt status, 5 transmit error count, 6 receive error count, 7 unmapped.

Top module: `canerr_report`

## Requirements
- R1: A pulse on `evt_i[k]` sets cause flag bit k at the next clock edge, whatever the value of enable bit k. Cause flag bit positions: 0 bus error, 1 error warning, 2 error passive, 3 bus-off entry, 4 bus-off recovery, 5 receive overrun, 6 overload frame, 7 bus lock.
- R2: A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A write can never set a flag.
- R3: When an event pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R4: `err_sts_o` is high one cycle after any flag bit is set together with its enable bit at address 1 (same bit layout as the flags). Clearing only enable bit 0 masks bus errors while the other causes still report.
- R5: Only bit 5 of address 3 is stored; the other bits read as 0. `err_irq_o` is `err_sts_o` qualified by that bit. Address 4 reads `err_sts_o` at bit 5 and 0 elsewhere.
- R6: When code-store bit 7 (display mode) is 1, a pulse on `code_evt_i` ORs its bits into code-store bits 6:0. Code bit positions: 0 stuff, 1 form, 2 ACK, 3 CRC, 4 bit error recessive, 5 bit error dominant, 6 ACK delimiter.
- R7: When display mode is 0, a nonzero pulse on `code_evt_i` replaces code-store bits 6:0 with exactly the pulsed bits.
- R8: A write to address 2 clears each code bit 6:0 whose data bit is 0, leaves each code bit whose data bit is 1 unchanged, and loads display mode from data bit 7.
- R9: Addresses 5 and 6 read `tec_i` and `rec_i`. Writes to addresses 4, 5, 6 and 7 change no state.
- R10: After reset, all flags, enables, codes, display mode, the interrupt enable, `err_sts_o`, `err_irq_o` and `rdata_o` are 0.
- R11: `rdata_o` shows the register selected by `addr_i` one clock later. The unmapped address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Error cause event pulses from the protocol engine |
| code_evt_i | input | 7 | Protocol error code pulses from the protocol engine |
| tec_i | input | 8 | Transmit error counter, read-only mirror |
| rec_i | input | 8 | Receive error counter, read-only mirror |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| err_sts_o | output | 1 | Combined error status (interrupt status bit 5) |
| err_irq_o | output | 1 | Combined error status qualified by the interrupt enable |

## Verification
The assertions assume that event and code inputs are one-cycle pulses that are fully settled at the clock edge. They also assume that software writes the code store only while no code pulse arrives with a different display-mode intent. The bench drives every pulse and every write on the falling edge and releases it on the next falling edge, so each pulse spans exactly one rising edge. The only deliberate overlap between a pulse and a write is the set-versus-clear collision, where both target the flag register in a single cycle.

// File: rtl/canerr_pkg.sv
package canerr_pkg;

  // Cause flag bit positions (flag and enable registers share them)
  localparam int unsigned CAUSE_BUS_ERR   = 0;
  localparam int unsigned CAUSE_WARN      = 1;
  localparam int unsigned CAUSE_PASSIVE   = 2;
  localparam int unsigned CAUSE_BOFF_IN   = 3;
  localparam int unsigned CAUSE_BOFF_OUT  = 4;
  localparam int unsigned CAUSE_OVERRUN   = 5;
  localparam int unsigned CAUSE_OVERLOAD  = 6;
  localparam int unsigned CAUSE_BUS_LOCK  = 7;

  // Interrupt status / enable position of the combined error bit
  localparam int unsigned IRQ_ERR_BIT = 5;

  // Register selector
  typedef enum logic [2:0] {
    SEL_FLAG   = 3'd0,
    SEL_ENA    = 3'd1,
    SEL_CODE   = 3'd2,
    SEL_IRQEN  = 3'd3,
    SEL_IRQSTS = 3'd4,
    SEL_TEC    = 3'd5,
    SEL_REC    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/canerr_w0c_reg.sv
// Sticky bit register: event bits set, written-zero bits clear, set wins.
// Optional replace mode loads the event vector when any event bit is set.
module canerr_w0c_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] keep_i,
  input  logic             replace_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q;
  logic             any_set;

  assign any_set = |set_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic hold;
    assign hold = q[b] & (~wr_i | keep_i[b]);

    always_ff @(posedge clk) begin
      if (rst) begin
        q[b] <= 1'b0;
      end else if (replace_i && any_set) begin
        q[b] <= set_i[b];
      end else begin
        q[b] <= hold | set_i[b];
      end
    end
  end

  assign q_o = q;

endmodule

// File: rtl/canerr_code_store.sv
// Protocol error code store with accumulate / latest-only display mode.
module canerr_code_store #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] code_evt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-2:0] code_o,
  output logic              dm_o
);

  localparam int unsigned CODE_W = DATA_W - 1;
  localparam int unsigned DM_BIT = DATA_W - 1;

  logic dm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_q <= 1'b0;
    end else if (wr_i) begin
      dm_q <= wdata_i[DM_BIT];
    end
  end

  canerr_w0c_reg #(
    .WIDTH (CODE_W)
  ) u_codes (
    .clk       (clk),
    .rst       (rst),
    .set_i     (code_evt_i),
    .wr_i      (wr_i),
    .keep_i    (wdata_i[CODE_W-1:0]),
    .replace_i (~dm_q),
    .q_o       (code_o)
  );

  assign dm_o = dm_q;

endmodule

// File: rtl/canerr_irq_gate.sv
// Combines enabled cause flags into one registered status bit and
// qualifies it with the interrupt enable.
module canerr_irq_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] ena_i,
  input  logic             ie_i,
  output logic             sts_o,
  output logic             irq_o
);

  logic any_en;
  logic sts_q;
  logic irq_q;

  assign any_en = |(flag_i & ena_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= any_en;
      irq_q <= any_en & ie_i;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/canerr_report.sv
module canerr_report
  import canerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-2:0] code_evt_i,
  input  logic [DATA_W-1:0] tec_i,
  input  logic [DATA_W-1:0] rec_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_sts_o,
  output logic              err_irq_o
);

  localparam int unsigned CAUSE_W = DATA_W;
  localparam int unsigned CODE_W  = DATA_W - 1;

  logic [CAUSE_W-1:0] flag_q;
  logic [CAUSE_W-1:0] ena_q;
  logic [CODE_W-1:0]  code_q;
  logic               dm_q;
  logic               ie_q;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rdata_q;

  logic wr_flag, wr_ena, wr_code, wr_ie;

  assign wr_flag = we_i && (addr_i == ADDR_W'(SEL_FLAG));
  assign wr_ena  = we_i && (addr_i == ADDR_W'(SEL_ENA));
  assign wr_code = we_i && (addr_i == ADDR_W'(SEL_CODE));
  assign wr_ie   = we_i && (addr_i == ADDR_W'(SEL_IRQEN));

  // Cause flags
  canerr_w0c_reg #(
    .WIDTH (CAUSE_W)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (evt_i),
    .wr_i      (wr_flag),
    .keep_i    (wdata_i),
    .replace_i (1'b0),
    .q_o       (flag_q)
  );

  // Cause enables and interrupt enable
  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_ena) ena_q <= wdata_i;
      if (wr_ie)  ie_q  <= wdata_i[IRQ_ERR_BIT];
    end
  end

  // Protocol error codes
  canerr_code_store #(
    .DATA_W (DATA_W)
  ) u_codes (
    .clk        (clk),
    .rst        (rst),
    .code_evt_i (code_evt_i),
    .wr_i       (wr_code),
    .wdata_i    (wdata_i),
    .code_o     (code_q),
    .dm_o       (dm_q)
  );

  // Combined status and interrupt
  canerr_irq_gate #(
    .WIDTH (CAUSE_W)
  ) u_gate (
    .clk    (clk),
    .rst    (rst),
    .flag_i (flag_q),
    .ena_i  (ena_q),
    .ie_i   (ie_q),
    .sts_o  (err_sts_o),
    .irq_o  (err_irq_o)
  );

  // Read path
  always_comb begin
    rd_next = '0;
    case (addr_i)
      ADDR_W'(SEL_FLAG):   rd_next = flag_q;
      ADDR_W'(SEL_ENA):    rd_next = ena_q;
      ADDR_W'(SEL_CODE):   rd_next = {dm_q, code_q};
      ADDR_W'(SEL_IRQEN):  rd_next[IRQ_ERR_BIT] = ie_q;
      ADDR_W'(SEL_IRQSTS): rd_next[IRQ_ERR_BIT] = err_sts_o;
      ADDR_W'(SEL_TEC):    rd_next = tec_i;
      ADDR_W'(SEL_REC):    rd_next = rec_i;
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/canerr_report_chk.sv
module canerr_report_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] evt_i,
  input logic [DATA_W-2:0] code_evt_i,
  input logic [DATA_W-1:0] flag_q,
  input logic [DATA_W-1:0] ena_q,
  input logic [DATA_W-2:0] code_q,
  input logic              dm_q,
  input logic              ie_q,
  input logic              err_sts_o,
  input logic              err_irq_o
);

  // R1
  flag_evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R2
  no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0));

  // R4
  err_sts_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_sts_o == (|($past(flag_q) & $past(ena_q)))));

  // R5
  irq_qual_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_irq_o == (err_sts_o && $past(ie_q))));

  // R6
  code_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_q && (|code_evt_i)) |=> ((code_q & $past(code_evt_i)) == $past(code_evt_i)));

  // R7
  code_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (!dm_q && (|code_evt_i)) |=> (code_q == $past(code_evt_i)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && code_q == '0 && !dm_q && !err_sts_o && !err_irq_o));

endmodule

bind canerr_report canerr_report_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .code_evt_i (code_evt_i),
  .flag_q     (flag_q),
  .ena_q      (ena_q),
  .code_q     (code_q),
  .dm_q       (dm_q),
  .ie_q       (ie_q),
  .err_sts_o  (err_sts_o),
  .err_irq_o  (err_irq_o)
);

// File: tb/canerr_report_bench.sv
module canerr_report_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_i = '0;
  logic [6:0] code_evt_i = '0;
  logic [7:0] tec_i = '0;
  logic [7:0] rec_i = '0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       err_sts_o;
  logic       err_irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  canerr_report u_canerr_report (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .code_evt_i (code_evt_i),
    .tec_i      (tec_i),
    .rec_i      (rec_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .err_sts_o  (err_sts_o),
    .err_irq_o  (err_irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    @(posedge clk);
    #1 d = rdata_o;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_code(input logic [6:0] v);
    @(negedge clk);
    code_evt_i = v;
    @(negedge clk);
    code_evt_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 err_sts", int'(err_sts_o), 0);
    check("R10 err_irq", int'(err_irq_o), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R10 reg", int'(d), 0);
    end
    rd(3'd7, d);
    check("R11 unmapped", int'(d), 0);
  endtask

  task automatic t_flag_set();
    logic [7:0] d;
    pulse_evt(8'h81);
    rd(3'd0, d);
    check("R1 flag set w/o enable", int'(d), 8'h81);
    check("R4 sts masked", int'(err_sts_o), 0);
  endtask

  task automatic t_flag_clear();
    logic [7:0] d;
    wr(3'd0, 8'hFE);
    rd(3'd0, d);
    check("R2 clear bit0", int'(d), 8'h80);
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    check("R2 ones keep", int'(d), 8'h80);
    wr(3'd0, 8'h7F);
    rd(3'd0, d);
    check("R2 clear bit7", int'(d), 8'h00);
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    check("R2 no sw set", int'(d), 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse_evt(8'h0C);
    @(negedge clk);
    we_i = 1'b1; addr_i = 3'd0; wdata_i = 8'hF3; evt_i = 8'h04;
    @(negedge clk);
    we_i = 1'b0; evt_i = '0;
    rd(3'd0, d);
    check("R3 set wins", int'(d), 8'h04);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_combined();
    logic [7:0] d;
    wr(3'd1, 8'hFE);
    rd(3'd1, d);
    check("R4 enable readback", int'(d), 8'hFE);
    pulse_evt(8'h01);
    @(posedge clk); #1;
    check("R4 bus error masked", int'(err_sts_o), 0);
    rd(3'd0, d);
    check("R1 bus error flag", int'(d), 8'h01);
    pulse_evt(8'h02);
    @(posedge clk); #1;
    check("R4 warning reports", int'(err_sts_o), 1);
    wr(3'd0, 8'h00);
    @(posedge clk); #1;
    check("R4 sts drops", int'(err_sts_o), 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(3'd1, 8'hFF);
    pulse_evt(8'h40);
    @(posedge clk); #1;
    check("R5 sts up", int'(err_sts_o), 1);
    check("R5 irq gated off", int'(err_irq_o), 0);
    wr(3'd3, 8'hFF);
    @(posedge clk); #1;
    check("R5 irq on", int'(err_irq_o), 1);
    rd(3'd3, d);
    check("R5 ie readback", int'(d), 8'h20);
    rd(3'd4, d);
    check("R5 status reg", int'(d), 8'h20);
    wr(3'd3, 8'hDF);
    @(posedge clk); #1;
    check("R5 irq off", int'(err_irq_o), 0);
    wr(3'd0, 8'h00);
    @(posedge clk); #1;
    rd(3'd4, d);
    check("R5 status cleared", int'(d), 8'h00);
  endtask

  task automatic t_code_replace();
    logic [7:0] d;
    pulse_code(7'h08);
    pulse_code(7'h20);
    rd(3'd2, d);
    check("R7 latest only", int'(d), 8'h20);
  endtask

  task automatic t_code_acc();
    logic [7:0] d;
    wr(3'd2, 8'h80);
    rd(3'd2, d);
    check("R8 dm set, codes cleared", int'(d), 8'h80);
    pulse_code(7'h08);
    pulse_code(7'h40);
    rd(3'd2, d);
    check("R6 accumulate", int'(d), 8'hC8);
  endtask

  task automatic t_code_clear();
    logic [7:0] d;
    wr(3'd2, 8'hBF);
    rd(3'd2, d);
    check("R8 clear bit6", int'(d), 8'h88);
    wr(3'd2, 8'h77);
    rd(3'd2, d);
    check("R8 clear bit3 and dm", int'(d), 8'h00);
    wr(3'd2, 8'h7F);
    rd(3'd2, d);
    check("R8 ones do not set", int'(d), 8'h00);
  endtask

  task automatic t_counters();
    logic [7:0] d;
    tec_i = 8'h5A; rec_i = 8'hA5;
    rd(3'd5, d);
    check("R9 tec", int'(d), 8'h5A);
    rd(3'd6, d);
    check("R9 rec", int'(d), 8'hA5);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd5, d);
    check("R9 tec after write", int'(d), 8'h5A);
    rd(3'd4, d);
    check("R9 status unwritable", int'(d), 8'h00);
    rd(3'd7, d);
    check("R11 unmapped after write", int'(d), 8'h00);
    rd(3'd0, d);
    check("R9 flags untouched", int'(d), 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      begin
        t_reset();
        t_flag_set();
        t_flag_clear();
        t_set_wins();
        t_combined();
        t_irq();
        t_code_replace();
        t_code_acc();
        t_code_clear();
        t_counters();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule